// File: doc/BRIEF.md
# Four-Ratio Multi-Modulus Prescaler

This block divides its input clock by 32, 33, 47 or 48. Two control bits choose the ratio. One bit selects the band: the low band gives 32/33 and the high band gives 47/48. The other bit selects either the base ratio of that band (32 or 48) or the neighbouring ratio (33 or 47).

Inside, a divider core counts either two or three input cycles. A binary chain of divide-by-two stages follows it, so the core runs 16 times per output period. A single mode-control term is the NAND of "not base" and "chain at its last state". That term is inverted in the high band. This is how the block reaches 47 and 48 with no extra storage element.

The output is a one-cycle pulse at the input clock rate, issued once per division period. Both control bits are captured only at a period boundary, so a period never mixes ratios.

Top module: `mmp_quad_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, `tick_out` is 0, the divider restarts a period, and the current `band_hi` and `base_ratio` values are captured for the first period.
- R2: With `band_hi`=0 and `base_ratio`=1, consecutive `tick_out` pulses are 32 clock cycles apart; the core divides by two throughout.
- R3: With `band_hi`=0 and `base_ratio`=0, pulses are 33 cycles apart; exactly one core cycle of three clocks occurs per period, and it is the last one.
- R4: With `band_hi`=1 and `base_ratio`=1, pulses are 48 cycles apart; the core divides by three throughout.
- R5: With `band_hi`=1 and `base_ratio`=0, pulses are 47 cycles apart; exactly one core cycle of two clocks occurs per period.
- R6: `band_hi` and `base_ratio` are sampled only at the clock edge that ends a period, which is the edge at which `tick_out` rises. That sample sets the ratio of the following period. Changes at any other time have no effect on the period in progress.
- R7: `tick_out` is high for exactly one cycle per period. The first pulse after reset is released rises at the N-th clock edge after release, where N is the selected ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| band_hi | input | 1 | 0 selects the 32/33 band, 1 selects the 47/48 band |
| base_ratio | input | 1 | 1 selects 32 or 48, 0 selects 33 or 47 |
| tick_out | output | 1 | One-cycle pulse once per division period |

## Verification
Several properties are checked on every cycle. The core counter never passes its third state, and it reaches that state only in divide-by-three mode. The captured controls hold still except at a period end. The output pulse is never two cycles wide. A free-running gap counter confirms that each period has the length the captured controls call for. What these per-cycle checks cannot show is the link from the input pins to the period that follows. That link covers the first pulse after reset, control changes made mid-period that must not take effect early, and the run of every ratio back to back. The bench's cycle model and its measured gaps cover that.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

    typedef struct packed {
        logic band_hi;
        logic base;
    } mmp_ctl_t;

    typedef enum logic {
        CORE_DIV2 = 1'b0,
        CORE_DIV3 = 1'b1
    } core_mode_e;

    // mode term: NAND of (not base) and chain-at-last-state, inverted in high band
    function automatic core_mode_e core_mode(mmp_ctl_t c, logic chain_last);
        logic mc;
        mc = ~((~c.base) & chain_last);
        return c.band_hi ? (mc ? CORE_DIV3 : CORE_DIV2)
                         : (mc ? CORE_DIV2 : CORE_DIV3);
    endfunction

    // expected period length, used by the checker only
    function automatic int period_len(mmp_ctl_t c, int stages);
        int runs;
        runs = 1 << stages;
        if (c.band_hi)
            return 3 * runs - (c.base ? 0 : 1);
        else
            return 2 * runs + (c.base ? 0 : 1);
    endfunction

endpackage

// File: rtl/mmp_dual_core.sv
module mmp_dual_core
    import mmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  core_mode_e mode,
    output logic       core_tick
);
    localparam int CW = 2;

    logic [CW-1:0] cnt_q;
    logic          at_end;

    always_comb begin
        if (mode == CORE_DIV3)
            at_end = (cnt_q == CW'(2));
        else
            at_end = (cnt_q == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (at_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign core_tick = at_end;

    assert_core_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q != CW'(3));

    assert_core_third_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(2)) |-> (mode == CORE_DIV3));

endmodule

// File: rtl/mmp_bin_chain.sv
module mmp_bin_chain #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [STAGES-1:0] state,
    output logic              all_ones
);
    logic [STAGES:0] carry;

    assign carry[0] = adv;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (carry[i])
                bit_q <= ~bit_q;
        end
        assign carry[i+1] = carry[i] & bit_q;
        assign state[i]   = bit_q;
    end

    assign all_ones = &state;

endmodule

// File: rtl/mmp_quad_prescaler.sv
module mmp_quad_prescaler
    import mmp_pkg::*;
#(
    parameter int CHAIN_STAGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic band_hi,
    input  logic base_ratio,
    output logic tick_out
);
    localparam int MAX_LEN = 3 << CHAIN_STAGES;

    mmp_ctl_t              ctl_q;
    core_mode_e            mode;
    logic                  core_tick;
    logic [CHAIN_STAGES-1:0] chain_state;
    logic                  chain_last;
    logic                  period_end;
    logic                  tick_q;

    assign mode       = core_mode(ctl_q, chain_last);
    assign period_end = core_tick & chain_last;

    mmp_dual_core u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .core_tick (core_tick)
    );

    mmp_bin_chain #(.STAGES(CHAIN_STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .adv      (core_tick),
        .state    (chain_state),
        .all_ones (chain_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{band_hi: band_hi, base: base_ratio};
            tick_q <= 1'b0;
        end else begin
            tick_q <= period_end;
            if (period_end)
                ctl_q <= '{band_hi: band_hi, base: base_ratio};
        end
    end

    assign tick_out = tick_q;

    // checker: cycles elapsed in the current period
    int gap_q;
    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= 0;
        else if (period_end)
            gap_q <= 0;
        else if (gap_q < MAX_LEN)
            gap_q <= gap_q + 1;
    end

    assert_period_len_R5: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (gap_q + 1 == period_len(ctl_q, CHAIN_STAGES)));

    assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(ctl_q));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        tick_out |=> !tick_out);

    assert_low_base_div2_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.band_hi && ctl_q.base) |-> (mode == CORE_DIV2));

    assert_high_base_div3_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.band_hi && ctl_q.base) |-> (mode == CORE_DIV3));

endmodule

// File: tb/test_mmp_quad_prescaler.sv
module test_mmp_quad_prescaler;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic band_hi = 1'b0;
    logic base_ratio = 1'b1;
    logic tick_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    mmp_quad_prescaler i_mmp_quad_prescaler (
        .clk        (clk),
        .rst        (rst),
        .band_hi    (band_hi),
        .base_ratio (base_ratio),
        .tick_out   (tick_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int want_ratio(logic hi, logic base);
        if (hi) return base ? 48 : 47;
        return base ? 32 : 33;
    endfunction

    function automatic string req_of(int r);
        case (r)
            32: return "R2";
            33: return "R3";
            48: return "R4";
            default: return "R5";
        endcase
    endfunction

    // behavioural reference: counts clocks, latches ratio at each period end
    int m_cnt = 0;
    int m_ratio = 32;
    bit m_pulse = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_ratio = want_ratio(band_hi, base_ratio);
            m_pulse = 0;
        end else if (m_cnt + 1 == m_ratio) begin
            m_pulse = 1;
            m_cnt = 0;
            m_ratio = want_ratio(band_hi, base_ratio);
        end else begin
            m_pulse = 0;
            m_cnt = m_cnt + 1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            checks++;
            if (rst) begin
                if (tick_out !== 1'b0) begin
                    failures++;
                    $display("FAIL R1 tick_out in reset actual=%b expected=0", tick_out);
                end
            end else if (tick_out !== m_pulse) begin
                failures++;
                $display("FAIL R6/R7 cycle model mismatch actual=%b expected=%b", tick_out, m_pulse);
            end
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (tick_out !== 1'b1);
    endtask

    task automatic measure_gap(int exp, string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tick_out !== 1'b1 && n < 200);
        checks++;
        if (n != exp) begin
            failures++;
            $display("FAIL %s gap actual=%0d expected=%0d", tag, n, exp);
        end
    endtask

    task automatic run_mode(logic hi, logic base);
        int r;
        r = want_ratio(hi, base);
        @(negedge clk);
        band_hi = hi;
        base_ratio = base;
        wait_tick();           // ends old period, latches new controls
        measure_gap(r, req_of(r));
        measure_gap(r, req_of(r));
    endtask

    task automatic first_pulse(logic hi, logic base);
        int n = 0;
        int r;
        r = want_ratio(hi, base);
        @(negedge clk);
        rst = 1'b1;
        band_hi = hi;
        base_ratio = base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do begin
            @(negedge clk);
            n++;
        end while (tick_out !== 1'b1 && n < 200);
        checks++;
        if (n != r) begin
            failures++;
            $display("FAIL R7 first pulse actual=%0d expected=%0d", n, r);
        end
    endtask

    initial begin
        // R1: reset state observed by the per-cycle check while rst is high
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R7: first pulse lands exactly one ratio after release (32)
        wait_tick();
        // R2, R3, R4, R5: each ratio measured on whole periods
        run_mode(1'b0, 1'b1);
        run_mode(1'b0, 1'b0);
        run_mode(1'b1, 1'b1);
        run_mode(1'b1, 1'b0);
        run_mode(1'b0, 1'b0);
        run_mode(1'b1, 1'b1);

        // R6: flip controls mid-period; the running period keeps its ratio
        band_hi = 1'b0; base_ratio = 1'b1;
        wait_tick();
        measure_gap(32, "R2");
        repeat (10) @(negedge clk);
        band_hi = 1'b1; base_ratio = 1'b1;
        repeat (5) @(negedge clk);
        band_hi = 1'b0; base_ratio = 1'b0;   // value present at the boundary
        begin
            int n = 15;
            do begin
                @(negedge clk);
                n++;
            end while (tick_out !== 1'b1 && n < 200);
            checks++;
            if (n != 32) begin
                failures++;
                $display("FAIL R6 period in progress actual=%0d expected=32", n);
            end
        end
        measure_gap(33, "R6");
        // glitch mid-period then restore before boundary: no effect
        repeat (7) @(negedge clk);
        band_hi = 1'b1;
        @(negedge clk);
        band_hi = 1'b0;
        begin
            int n = 8;
            do begin
                @(negedge clk);
                n++;
            end while (tick_out !== 1'b1 && n < 200);
            checks++;
            if (n != 33) begin
                failures++;
                $display("FAIL R6 glitch actual=%0d expected=33", n);
            end
        end
        measure_gap(33, "R6");

        // R1, R7: reset captures controls for the first period
        first_pulse(1'b1, 1'b0);
        first_pulse(1'b1, 1'b1);
        first_pulse(1'b0, 1'b0);

        // pseudo-random control changes checked by the cycle model (R6)
        for (int k = 0; k < 60; k++) begin
            repeat ((k * 7) % 23 + 1) @(negedge clk);
            band_hi = k[0] ^ k[2];
            base_ratio = k[1];
        end
        repeat (60) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule